// File: doc/BRIEF.md
# Two-Phase PWM Pulse Steering Unit

This block accepts one single-phase PWM waveform and hands its pulses out in turn to two outputs, so that a push-pull stage sees two phases at half the incoming switching rate, placed half an output period apart. The incoming waveform sets both the timing of the steering and the width of every pulse. Each input pulse reaches exactly one output, which keeps the on-time of the two phases equal and prevents a net DC bias in the transformer that follows.

The PWM input is brought into the system clock domain through a chain of flip-flops. A one-bit phase select is held in a toggle register and flips on each falling edge of the synchronised PWM. Both outputs are gated and registered from the synchronised level and the select. An enable pin forces both outputs low and returns the select to phase A. After enable rises, the block waits for the PWM to be low before it passes any pulse, so it never emits a partial pulse. The block has no data stream, so every pin is plain control.

Top module: `pwm_phase_splitter`

## Requirements
- R1: After reset both outputs are low, and the first full pulse accepted afterwards is driven on phase A.
- R2: A pulse that the block accepts appears on one output with the same width in clock cycles as the input pulse. The output rises on the third rising clock edge after the input rises, counting the edge that first samples it.
- R3: Phase A and phase B are never high in the same cycle.
- R4: Accepted pulses alternate between the outputs: A, B, A, B and so on. Each output therefore switches at half the input pulse rate.
- R5: With enable low, both outputs are low one clock after enable is sampled low, and no pulse is passed. After enable returns high, the next accepted pulse goes to phase A.
- R6: A pulse that is already high when enable rises is not passed to either output and does not advance the phase select.
- R7: The phase select changes only while the synchronised PWM is low, so no pulse is split between the two outputs, even when the low gap is a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Steering enable; low forces both outputs low and rearms phase A |
| pwm_in | input | 1 | Single-phase PWM, may be asynchronous to clk |
| phase_a | output | 1 | Steered PWM for the first push-pull phase |
| phase_b | output | 1 | Steered PWM for the second push-pull phase |

## Verification
The assertions assume that the PWM stays at each level for at least one full clock cycle once it is synchronised. They also assume that enable is synchronous to clk. Pulses narrower than a clock period could otherwise vanish between samples, and the alternation property would then see a select that moves without a matching output pulse. The stimulus changes pwm_in and en only on falling clock edges, and it holds every high and low level for whole cycles, with a one-cycle gap as the shortest. Cases where enable rises or falls during a pulse are placed deliberately, so that each exercises the arming and forced-low paths.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Which output owns the next accepted pulse
  typedef enum logic {
    PH_B = 1'b0,
    PH_A = 1'b1
  } phase_e;

  localparam int unsigned PPS_MIN_SYNC = 2;
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TOP-1:0], d};
      end
    end
  endgenerate

  assign q = chain[TOP];
endmodule

// File: rtl/pps_edge.sv
module pps_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign fall = lvl_d & ~lvl;
endmodule

// File: rtl/pps_steer.sv
module pps_steer
  import pps_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   lvl,
  input  logic   fall,
  output phase_e sel,
  output logic   armed
);
  phase_e sel_q;
  logic   armed_q;
  logic   advance;

  // Only a pulse that was passed in full moves the select on
  assign advance = en & armed_q & fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= PH_A;
      armed_q <= 1'b0;
    end else if (!en) begin
      sel_q   <= PH_A;
      armed_q <= 1'b0;
    end else begin
      if (advance) sel_q <= (sel_q == PH_A) ? PH_B : PH_A;
      if (!lvl)    armed_q <= 1'b1;
    end
  end

  assign sel   = sel_q;
  assign armed = armed_q;

  AST_SEL_MOVES_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$stable(sel_q)) |-> !$past(lvl)); // R7

  AST_ARM_ON_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> !$past(lvl)); // R6

  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(armed_q) && $past(fall)) |-> (sel_q != $past(sel_q))); // R4

  AST_DISABLE_REARMS_A: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sel_q == PH_A && !armed_q)); // R5
endmodule

// File: rtl/pwm_phase_splitter.sv
module pwm_phase_splitter
  import pps_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = PPS_MIN_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pwm_in,
  output logic phase_a,
  output logic phase_b
);
  logic   lvl_s;
  logic   fall_s;
  logic   armed;
  phase_e sel;
  logic   pa_q, pb_q;

  pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwm_in),
    .q   (lvl_s)
  );

  pps_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl_s),
    .fall (fall_s)
  );

  pps_steer u_steer (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .lvl   (lvl_s),
    .fall  (fall_s),
    .sel   (sel),
    .armed (armed)
  );

  // Registered gating keeps the outputs free of combinational glitches
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      pa_q <= armed & lvl_s & (sel == PH_A);
      pb_q <= armed & lvl_s & (sel == PH_B);
    end
  end

  assign phase_a = pa_q;
  assign phase_b = pb_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(pa_q && pb_q)); // R3

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pa_q && !pb_q)); // R5

  AST_OUT_FOLLOWS_PWM: assert property (@(posedge clk) disable iff (rst)
    (pa_q || pb_q) |-> $past(lvl_s)); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!pa_q && !pb_q)); // R1
endmodule

// File: tb/sim_pwm_phase_splitter.sv
module sim_pwm_phase_splitter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic pwm = 1'b0;
  logic pa, pb;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  int wa = 0, wb = 0;
  int rec_n = 0;
  int rec_ph [0:255];
  int rec_w  [0:255];
  bit overlap = 1'b0;

  pwm_phase_splitter u0 (
    .clk(clk), .rst(rst), .en(en), .pwm_in(pwm),
    .phase_a(pa), .phase_b(pb)
  );

  always #2 clk = ~clk;

  // Pulse recorder on the falling edge: phase 0 = A, 1 = B
  always @(negedge clk) begin
    if (!rst) begin
      if (pa && pb) overlap = 1'b1;
      if (pa) wa++;
      else if (wa > 0) begin
        rec_ph[rec_n] = 0; rec_w[rec_n] = wa; rec_n++; wa = 0;
      end
      if (pb) wb++;
      else if (wb > 0) begin
        rec_ph[rec_n] = 1; rec_w[rec_n] = wb; rec_n++; wb = 0;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected <= 20000", cyc);
      summary();
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rec(input int idx, input int ph, input int w, input string tag);
    chk(rec_n > idx, 1, {tag, " pulse present"});
    if (rec_n > idx) begin
      chk(rec_ph[idx], ph, {tag, " phase"});
      chk(rec_w[idx], w, {tag, " width"});
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    pwm = 1'b1;
    repeat (hi) @(negedge clk);
    pwm = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pa, 0, "R1 phase_a in reset");
    chk(pb, 0, "R1 phase_b in reset");
    rst = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    chk(pa | pb, 0, "R1 outputs idle after reset");
  endtask

  task automatic t_alternate();
    int base;
    base = rec_n;
    pulse(3, 4); pulse(5, 4); pulse(2, 4); pulse(7, 6);
    chk_rec(base,     0, 3, "R1 R2 R4 first pulse");
    chk_rec(base + 1, 1, 5, "R2 R4 second pulse");
    chk_rec(base + 2, 0, 2, "R2 R4 third pulse");
    chk_rec(base + 3, 1, 7, "R2 R4 fourth pulse");
  endtask

  task automatic t_tight_gap();
    int base;
    base = rec_n;
    pulse(4, 1); pulse(4, 1); pulse(1, 1); pulse(1, 6);
    chk_rec(base,     0, 4, "R7 one-cycle gap p0");
    chk_rec(base + 1, 1, 4, "R7 one-cycle gap p1");
    chk_rec(base + 2, 0, 1, "R7 one-cycle gap p2");
    chk_rec(base + 3, 1, 1, "R7 one-cycle gap p3");
  endtask

  task automatic t_latency();
    pwm = 1'b1;
    repeat (2) @(negedge clk);
    chk(pa, 0, "R2 latency before third edge");
    @(negedge clk);
    chk(pa, 1, "R2 latency at third edge");
    repeat (2) @(negedge clk);
    pwm = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_disable();
    int base;
    pulse(3, 5);              // lands on B
    en = 1'b0;
    @(negedge clk);
    base = rec_n;
    pulse(4, 5);              // must be dropped
    chk(rec_n - base, 0, "R5 no pulse while disabled");
    chk(pa | pb, 0, "R5 outputs low while disabled");
    en = 1'b1;
    repeat (2) @(negedge clk);
    base = rec_n;
    pulse(3, 6);
    chk_rec(base, 0, 3, "R5 after re-enable goes to A");
  endtask

  task automatic t_disable_mid();
    pwm = 1'b1;
    repeat (5) @(negedge clk);
    chk(pa, 0, "R5 mid pulse active on B");
    chk(pb, 1, "R5 mid pulse active on B (pb)");
    en = 1'b0;
    @(negedge clk);
    chk(pa | pb, 0, "R5 forced low one clock after disable");
    pwm = 1'b0;
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_enable_mid();
    int base;
    en = 1'b0;
    pwm = 1'b1;
    repeat (4) @(negedge clk);
    base = rec_n;
    en = 1'b1;
    repeat (5) @(negedge clk);
    chk(pa | pb, 0, "R6 partial pulse blocked");
    pwm = 1'b0;
    repeat (5) @(negedge clk);
    chk(rec_n - base, 0, "R6 no pulse recorded");
    pulse(2, 6);
    chk_rec(base, 0, 2, "R6 select not advanced");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_alternate();
    t_tight_gap();
    t_latency();
    t_disable();
    t_disable_mid();
    t_enable_mid();
    chk(overlap, 0, "R3 outputs never both high");
    summary();
  end
endmodule